// File: doc/BRIEF.md
# Ring Node ID Assignment Controller

Each node on a unidirectional ring of up to sixteen nodes has one copy of this block. It gives that node its address after a system reset. The node whose master-select input is high becomes node 0. It sends a steady stream of ID-carrying symbols downstream. Every other node adds one to the ID it receives, keeps the result as its own address and passes the larger value on. When the stream gets back to node 0, the value it carries is the highest ID on the ring. Node 0 then sends that value around the ring again under a second type code, so that every node learns the ring size.

A symbol is 32 bits wide and travels with a 2-bit type field and a frame bit. The ID sits in the top four bits, and during initialization the 28 bits below it are all ones. The type codes are 00 for null, 01 for ID assignment, 10 for ring-size broadcast and 11 for data. The downstream symbol is registered, so it follows the upstream symbol by one clock.

When initialization ends, the node shows two symbols on its client port, one per cycle: first its own ID, then the highest ID. The `node_id` and `max_id` outputs hold both values for reading at any later time.

The controller state machine has these states:

- `ST_IDLE` is the setup cycle after reset.
- `ST_SEED` is used only by the master, while it sends the ID stream.
- `ST_GET_ID` is a non-master node waiting for its ID.
- `ST_GET_MAX` is a node waiting for the ring size.
- `ST_ANN_ID` and `ST_ANN_MAX` are the two cycles in which the client announcements are shown.
- `ST_RUN` is the state after initialization.

Transitions:

- `ST_IDLE` goes to `ST_SEED` on the master and to `ST_GET_ID` on any other node.
- `ST_SEED` goes to `ST_GET_MAX` when an ID-assignment symbol arrives.
- `ST_GET_ID` goes to `ST_GET_MAX` when an ID-assignment symbol arrives that does not overflow.
- `ST_GET_MAX` goes to `ST_ANN_ID` when a ring-size symbol arrives.
- `ST_ANN_ID` goes to `ST_ANN_MAX`, which goes to `ST_RUN`, one cycle each.

Top module: `ring_id_init`

## Requirements
- R1: While `rst_n` is low, the outputs are all zero: null type, zero symbol, frame 0, `node_id`/`max_id` 0, no done and no error, whatever the inputs. The first clock edge after release is a setup cycle. In that cycle a non-master node ignores its input and drives a null symbol.
- R2: From the first edge after release, the master drives type 01, symbol 0x0FFFFFFF and frame 1 on every cycle. It keeps doing so until a type-01 symbol reaches it; any other input leaves the seed unchanged.
- R3: A non-master node that receives type 01 with an ID (bits 31:28) below 15 does two things one cycle later. It sets `node_id` to ID+1 on its first such symbol. It forwards the symbol with bits 31:28 replaced by ID+1 and bits 27:0, the type and the frame unchanged. It treats every later type-01 symbol the same way before done.
- R4: When a type-01 symbol reaches the master, the master forwards it with the type changed to 10, keeping the symbol bits and the frame. It also records bits 31:28 as `max_id`.
- R5: A non-master node forwards type-10 symbols unmodified. It records bits 31:28 of the first one received after its ID as `max_id`.
- R6: A type-10 symbol that reaches the master ends its initialization. The master sets `max_id` from it, drives a null symbol downstream and does not forward it.
- R7: On the edge that captures the ring size, `init_done` rises. On that same edge the client port shows type 01 with `{node_id, 28 ones}` and frame 1. On the next cycle it shows type 10 with `{max_id, 28 ones}`. It is null after that.
- R8: After done, `node_id`, `max_id` and `init_done` hold until reset. Type-01 and type-10 symbols are then ignored: a non-master node forwards them unmodified, and the master drops them by driving null. Data symbols are forwarded on both.
- R9: A non-master node that receives type 01 with ID 15 before done sets `id_err`. The flag stays set until reset. For that symbol the node drives null and leaves `node_id` unchanged, and it does not reach done.
- R10: A non-master node forwards null and data (type 11) symbols unmodified while it waits for its ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | High on exactly one node: that node becomes node 0 |
| up_sym | input | 32 | Upstream symbol, ID in bits 31:28 |
| up_type | input | 2 | Upstream type: 00 null, 01 ID assign, 10 ring size, 11 data |
| up_frame | input | 1 | Upstream frame bit |
| dn_sym | output | 32 | Downstream symbol (registered) |
| dn_type | output | 2 | Downstream type |
| dn_frame | output | 1 | Downstream frame bit |
| cli_sym | output | 32 | Client-side receive symbol carrying the announcements |
| cli_type | output | 2 | Client-side type, 00 when idle |
| cli_frame | output | 1 | Client-side frame bit |
| node_id | output | 4 | This node's assigned ID (diagnostic readout) |
| max_id | output | 4 | Highest ID on the ring (diagnostic readout) |
| init_done | output | 1 | High once the ring size has been captured |
| id_err | output | 1 | Sticky ID overflow flag |

## Verification
Every downstream and client result is due exactly one clock edge after the upstream symbol that causes it. The second announcement is due one cycle after the first, and the client port is null on the cycle after that. The bench drives inputs on the falling edge and steps one full cycle before it reads any output. Each check therefore samples the outputs half a period after the rising edge that registered them. The master scenario, the non-master scenario and the overflow scenario each start from a fresh reset, so that the setup cycle (R1) lands on a known step.

// File: rtl/rii_pkg.sv
package rii_pkg;

    typedef enum logic [1:0] {
        TY_NULL   = 2'b00,
        TY_ASSIGN = 2'b01,
        TY_SIZE   = 2'b10,
        TY_DATA   = 2'b11
    } sym_type_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEED    = 3'd1,
        ST_GET_ID  = 3'd2,
        ST_GET_MAX = 3'd3,
        ST_ANN_ID  = 3'd4,
        ST_ANN_MAX = 3'd5,
        ST_RUN     = 3'd6
    } init_state_e;

endpackage

// File: rtl/rii_id_incr.sv
module rii_id_incr #(
    parameter int ID_W = 4
) (
    input  logic [ID_W-1:0] id_in,
    output logic [ID_W-1:0] id_out,
    output logic            ovf
);
    localparam logic [ID_W-1:0] ID_TOP = {ID_W{1'b1}};

    always_comb begin
        ovf    = (id_in == ID_TOP);
        id_out = id_in + ID_W'(1);
    end
endmodule

// File: rtl/rii_sym_reg.sv
module rii_sym_reg #(
    parameter int SYM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] d_sym,
    input  logic [1:0]       d_type,
    input  logic             d_frame,
    output logic [SYM_W-1:0] q_sym,
    output logic [1:0]       q_type,
    output logic             q_frame
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_sym   <= '0;
            q_type  <= 2'b00;
            q_frame <= 1'b0;
        end else begin
            q_sym   <= d_sym;
            q_type  <= d_type;
            q_frame <= d_frame;
        end
    end
endmodule

// File: rtl/rii_ctrl.sv
module rii_ctrl
    import rii_pkg::*;
#(
    parameter int SYM_W = 32,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic [SYM_W-1:0] up_sym,
    input  logic [1:0]       up_type,
    input  logic             up_frame,
    input  logic [ID_W-1:0]  inc_id,
    input  logic             inc_ovf,
    output logic [SYM_W-1:0] dn_sym_d,
    output logic [1:0]       dn_type_d,
    output logic             dn_frame_d,
    output logic [SYM_W-1:0] cli_sym_d,
    output logic [1:0]       cli_type_d,
    output logic             cli_frame_d,
    output logic [ID_W-1:0]  node_id,
    output logic [ID_W-1:0]  max_id,
    output logic             init_done,
    output logic             id_err
);
    localparam int PAY_W = SYM_W - ID_W;
    localparam logic [PAY_W-1:0] PAY_ONES = {PAY_W{1'b1}};

    init_state_e     state_q, state_d;
    logic [ID_W-1:0] node_q, node_d;
    logic [ID_W-1:0] max_q, max_d;
    logic            err_q, err_d;
    logic [ID_W-1:0] up_id;
    sym_type_e       up_ty;
    logic            init_kind;

    assign up_id     = up_sym[SYM_W-1 -: ID_W];
    assign up_ty     = sym_type_e'(up_type);
    assign init_kind = (up_ty == TY_ASSIGN) || (up_ty == TY_SIZE);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            node_q  <= '0;
            max_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            node_q  <= node_d;
            max_q   <= max_d;
            err_q   <= err_d;
        end
    end

    // next state and next outputs
    always_comb begin
        state_d     = state_q;
        node_d      = node_q;
        max_d       = max_q;
        err_d       = err_q;
        dn_sym_d    = up_sym;
        dn_type_d   = up_type;
        dn_frame_d  = up_frame;
        cli_sym_d   = '0;
        cli_type_d  = TY_NULL;
        cli_frame_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_master) begin
                    state_d    = ST_SEED;
                    dn_sym_d   = {{ID_W{1'b0}}, PAY_ONES};
                    dn_type_d  = TY_ASSIGN;
                    dn_frame_d = 1'b1;
                end else begin
                    state_d    = ST_GET_ID;
                    dn_sym_d   = '0;
                    dn_type_d  = TY_NULL;
                    dn_frame_d = 1'b0;
                end
            end
            ST_SEED: begin
                if (up_ty == TY_ASSIGN) begin
                    max_d     = up_id;
                    dn_type_d = TY_SIZE;
                    state_d   = ST_GET_MAX;
                end else begin
                    dn_sym_d   = {{ID_W{1'b0}}, PAY_ONES};
                    dn_type_d  = TY_ASSIGN;
                    dn_frame_d = 1'b1;
                end
            end
            ST_GET_ID: begin
                if (up_ty == TY_ASSIGN) begin
                    if (inc_ovf) begin
                        err_d      = 1'b1;
                        dn_sym_d   = '0;
                        dn_type_d  = TY_NULL;
                        dn_frame_d = 1'b0;
                    end else begin
                        node_d   = inc_id;
                        dn_sym_d = {inc_id, up_sym[PAY_W-1:0]};
                        state_d  = ST_GET_MAX;
                    end
                end
            end
            ST_GET_MAX: begin
                if (is_master) begin
                    dn_sym_d   = '0;
                    dn_type_d  = TY_NULL;
                    dn_frame_d = 1'b0;
                    if (up_ty == TY_ASSIGN) begin
                        max_d      = up_id;
                        dn_sym_d   = up_sym;
                        dn_type_d  = TY_SIZE;
                        dn_frame_d = up_frame;
                    end
                end else if (up_ty == TY_ASSIGN) begin
                    if (inc_ovf) begin
                        err_d      = 1'b1;
                        dn_sym_d   = '0;
                        dn_type_d  = TY_NULL;
                        dn_frame_d = 1'b0;
                    end else begin
                        dn_sym_d = {inc_id, up_sym[PAY_W-1:0]};
                    end
                end
                if (up_ty == TY_SIZE) begin
                    max_d       = up_id;
                    state_d     = ST_ANN_ID;
                    cli_sym_d   = {node_q, PAY_ONES};
                    cli_type_d  = TY_ASSIGN;
                    cli_frame_d = 1'b1;
                end
            end
            ST_ANN_ID, ST_ANN_MAX, ST_RUN: begin
                if (is_master && init_kind) begin
                    dn_sym_d   = '0;
                    dn_type_d  = TY_NULL;
                    dn_frame_d = 1'b0;
                end
                if (state_q == ST_ANN_ID) begin
                    state_d     = ST_ANN_MAX;
                    cli_sym_d   = {max_q, PAY_ONES};
                    cli_type_d  = TY_SIZE;
                    cli_frame_d = 1'b1;
                end else if (state_q == ST_ANN_MAX) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign node_id   = node_q;
    assign max_id    = max_q;
    assign id_err    = err_q;
    assign init_done = (state_q == ST_ANN_ID) || (state_q == ST_ANN_MAX)
                       || (state_q == ST_RUN);

    // R9
    ovf_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GET_ID && up_ty == TY_ASSIGN && inc_ovf)
        |=> (state_q == ST_GET_ID) && id_err && $stable(node_id));

    // R2
    seed_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED && up_ty == TY_ASSIGN) |=> (state_q == ST_GET_MAX) && (max_id == $past(up_id)));

endmodule

// File: rtl/ring_id_init.sv
module ring_id_init
    import rii_pkg::*;
#(
    parameter int SYM_W = 32,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic [SYM_W-1:0] up_sym,
    input  logic [1:0]       up_type,
    input  logic             up_frame,
    output logic [SYM_W-1:0] dn_sym,
    output logic [1:0]       dn_type,
    output logic             dn_frame,
    output logic [SYM_W-1:0] cli_sym,
    output logic [1:0]       cli_type,
    output logic             cli_frame,
    output logic [ID_W-1:0]  node_id,
    output logic [ID_W-1:0]  max_id,
    output logic             init_done,
    output logic             id_err
);
    logic [ID_W-1:0]  inc_id;
    logic             inc_ovf;
    logic [SYM_W-1:0] dn_sym_d, cli_sym_d;
    logic [1:0]       dn_type_d, cli_type_d;
    logic             dn_frame_d, cli_frame_d;

    rii_id_incr #(.ID_W(ID_W)) u_incr (
        .id_in  (up_sym[SYM_W-1 -: ID_W]),
        .id_out (inc_id),
        .ovf    (inc_ovf)
    );

    rii_ctrl #(.SYM_W(SYM_W), .ID_W(ID_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_master   (is_master),
        .up_sym      (up_sym),
        .up_type     (up_type),
        .up_frame    (up_frame),
        .inc_id      (inc_id),
        .inc_ovf     (inc_ovf),
        .dn_sym_d    (dn_sym_d),
        .dn_type_d   (dn_type_d),
        .dn_frame_d  (dn_frame_d),
        .cli_sym_d   (cli_sym_d),
        .cli_type_d  (cli_type_d),
        .cli_frame_d (cli_frame_d),
        .node_id     (node_id),
        .max_id      (max_id),
        .init_done   (init_done),
        .id_err      (id_err)
    );

    rii_sym_reg #(.SYM_W(SYM_W)) u_dn_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_sym   (dn_sym_d),
        .d_type  (dn_type_d),
        .d_frame (dn_frame_d),
        .q_sym   (dn_sym),
        .q_type  (dn_type),
        .q_frame (dn_frame)
    );

    rii_sym_reg #(.SYM_W(SYM_W)) u_cli_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_sym   (cli_sym_d),
        .d_type  (cli_type_d),
        .d_frame (cli_frame_d),
        .q_sym   (cli_sym),
        .q_type  (cli_type),
        .q_frame (cli_frame)
    );

    // R7
    ann_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cli_type == TY_ASSIGN) |=> (cli_type == TY_SIZE));

    // R7
    ann_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cli_type == TY_SIZE) |=> (cli_type == TY_NULL));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done && $stable(node_id) && $stable(max_id));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |=> id_err);

    // R5
    size_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !is_master && up_type == TY_SIZE)
        |=> (dn_type == TY_SIZE) && (dn_sym == $past(up_sym)));

    // R6
    master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && init_done && (up_type == TY_ASSIGN || up_type == TY_SIZE))
        |=> (dn_type == TY_NULL));

endmodule

// File: tb/ring_id_init_test.sv
module ring_id_init_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_master = 1'b0;
    logic [31:0] up_sym = '0;
    logic [1:0]  up_type = 2'b00;
    logic        up_frame = 1'b0;
    logic [31:0] dn_sym, cli_sym;
    logic [1:0]  dn_type, cli_type;
    logic        dn_frame, cli_frame;
    logic [3:0]  node_id, max_id;
    logic        init_done, id_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic [1:0] TN = 2'b00, TA = 2'b01, TS = 2'b10, TD = 2'b11;

    always #5 clk = ~clk;

    ring_id_init uut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .up_sym(up_sym), .up_type(up_type), .up_frame(up_frame),
        .dn_sym(dn_sym), .dn_type(dn_type), .dn_frame(dn_frame),
        .cli_sym(cli_sym), .cli_type(cli_type), .cli_frame(cli_frame),
        .node_id(node_id), .max_id(max_id),
        .init_done(init_done), .id_err(id_err)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] t, input logic [31:0] s, input logic f);
        up_type  = t;
        up_sym   = s;
        up_frame = f;
        @(negedge clk);
    endtask

    task automatic reset_node(input logic m);
        rst_n     = 1'b0;
        is_master = m;
        drive(TA, 32'h2FFFFFFF, 1'b1);
        drive(TS, 32'h9FFFFFFF, 1'b1);
        chk("R1 dn_type in reset", 32'(dn_type), 32'(TN));
        chk("R1 dn_sym in reset", dn_sym, 32'h0);
        chk("R1 cli_type in reset", 32'(cli_type), 32'(TN));
        chk("R1 ids in reset", {24'h0, node_id, max_id}, 32'h0);
        chk("R1 flags in reset", {30'h0, init_done, id_err}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_master;
        reset_node(1'b1);
        drive(TN, 32'h0, 1'b0);
        chk("R2 seed type", 32'(dn_type), 32'(TA));
        chk("R2 seed sym", dn_sym, 32'h0FFFFFFF);
        chk("R2 seed frame", 32'(dn_frame), 32'h1);
        drive(TD, 32'hABCD0000, 1'b0);
        chk("R2 seed held", {dn_sym[31:2], dn_type}, {30'h03FFFFFF, TA});
        drive(TA, 32'h5FFFFFFF, 1'b1);
        chk("R4 retyped", 32'(dn_type), 32'(TS));
        chk("R4 sym kept", dn_sym, 32'h5FFFFFFF);
        chk("R4 max", 32'(max_id), 32'h5);
        chk("R4 not done", 32'(init_done), 32'h0);
        drive(TA, 32'h5FFFFFFF, 1'b0);
        chk("R4 second retype", {dn_frame, dn_type}, {1'b0, TS});
        drive(TS, 32'h5FFFFFFF, 1'b1);
        chk("R6 done", 32'(init_done), 32'h1);
        chk("R6 dropped", 32'(dn_type), 32'(TN));
        chk("R7 id ann type", 32'(cli_type), 32'(TA));
        chk("R7 id ann sym", cli_sym, 32'h0FFFFFFF);
        chk("R7 id ann frame", 32'(cli_frame), 32'h1);
        drive(TN, 32'h0, 1'b0);
        chk("R7 max ann type", 32'(cli_type), 32'(TS));
        chk("R7 max ann sym", cli_sym, 32'h5FFFFFFF);
        drive(TN, 32'h0, 1'b0);
        chk("R7 ann over", 32'(cli_type), 32'(TN));
        drive(TA, 32'h3FFFFFFF, 1'b1);
        chk("R8 master drops 01", 32'(dn_type), 32'(TN));
        chk("R8 max held", 32'(max_id), 32'h5);
        drive(TD, 32'h11112222, 1'b0);
        chk("R8 master forwards data", dn_sym, 32'h11112222);
        chk("R8 data type", 32'(dn_type), 32'(TD));
    endtask

    task automatic t_slave;
        reset_node(1'b0);
        drive(TA, 32'h2FFFFFFF, 1'b1);
        chk("R1 setup cycle null", 32'(dn_type), 32'(TN));
        chk("R1 setup id", 32'(node_id), 32'h0);
        drive(TD, 32'h12345678, 1'b0);
        chk("R10 data fwd", dn_sym, 32'h12345678);
        chk("R10 data type", {dn_frame, dn_type}, {1'b0, TD});
        drive(TA, 32'h2FFFFFFF, 1'b1);
        chk("R3 incremented", dn_sym, 32'h3FFFFFFF);
        chk("R3 type frame", {dn_frame, dn_type}, {1'b1, TA});
        chk("R3 node id", 32'(node_id), 32'h3);
        drive(TA, 32'h6FFFFFFF, 1'b0);
        chk("R3 later increment", dn_sym, 32'h7FFFFFFF);
        chk("R3 later frame", {dn_frame, dn_type}, {1'b0, TA});
        chk("R3 id kept", 32'(node_id), 32'h3);
        drive(TS, 32'h7FFFFFFF, 1'b1);
        chk("R5 size fwd", dn_sym, 32'h7FFFFFFF);
        chk("R5 size type", 32'(dn_type), 32'(TS));
        chk("R5 max", 32'(max_id), 32'h7);
        chk("R7 done", 32'(init_done), 32'h1);
        chk("R7 id ann", cli_sym, 32'h3FFFFFFF);
        chk("R7 id ann type", 32'(cli_type), 32'(TA));
        drive(TN, 32'h0, 1'b0);
        chk("R7 max ann", cli_sym, 32'h7FFFFFFF);
        chk("R7 max ann type", 32'(cli_type), 32'(TS));
        drive(TA, 32'h9FFFFFFF, 1'b1);
        chk("R7 ann null", 32'(cli_type), 32'(TN));
        chk("R8 01 fwd unmodified", dn_sym, 32'h9FFFFFFF);
        chk("R8 id held", 32'(node_id), 32'h3);
        drive(TS, 32'h1FFFFFFF, 1'b1);
        chk("R8 10 fwd", dn_sym, 32'h1FFFFFFF);
        chk("R8 max held", 32'(max_id), 32'h7);
        chk("R8 done held", 32'(init_done), 32'h1);
    endtask

    task automatic t_overflow;
        reset_node(1'b0);
        drive(TN, 32'h0, 1'b0);
        drive(TA, 32'hFFFFFFFF, 1'b1);
        chk("R9 err set", 32'(id_err), 32'h1);
        chk("R9 dn null", 32'(dn_type), 32'(TN));
        chk("R9 id unchanged", 32'(node_id), 32'h0);
        chk("R9 no done", 32'(init_done), 32'h0);
        drive(TN, 32'h0, 1'b0);
        chk("R9 err sticky", 32'(id_err), 32'h1);
        rst_n = 1'b0;
        drive(TN, 32'h0, 1'b0);
        chk("R1 err cleared", 32'(id_err), 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_master();
        t_slave();
        t_overflow();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule